// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block owns the byte-wide control register that arms program, page-erase and whole-array erase operations on an on-chip flash array. It watches three bus events: writes to the control register, a read of the block-protect register, and writes that land inside the flash address range. From these it decides whether the ordered preparation steps took place. Only when they did, and only after a minimum setup time, does it let software switch on the high-voltage enable that drives the array.

The steps of a sequence are as follows. Software first selects program or erase, and clears or sets the whole-array bit for an erase. It then reads the block-protect register and writes any data to an address inside the target range. That write latches the target address. The setup time is counted in system clocks from the latching write. Software then sets the high-voltage bit. Clearing that bit, or dropping both select bits, ends the operation.

Top module: `flash_pe_seq`

## Requirements
- R1: After a synchronous reset all control bits are 0: `ctl_rdata` reads 8'h00, `hv_en` is 0 and `tgt_addr` is 0.
- R2: The control register layout is bit 0 program select, bit 1 erase select, bit 2 whole-array select (1 = whole array, 0 = one page) and bit 3 high-voltage request. Bits 7 to 4 always read 0. The whole-array bit takes any written value.
- R3: Program and erase select are never both 1. A write asking for both, or asking for one while the other is already 1, leaves both select bits unchanged. The other bits of that write still apply.
- R4: The tracker advances only in this order: a control write that selects program or erase (from idle), then a block-protect read, then a flash-range write. A flash write before the protect read returns the tracker to idle. A protect read while idle is ignored.
- R5: The latching write loads `tgt_addr` with one of three values. For program it is the full write address. For page erase it is that address with the low PAGE_BITS bits cleared (the page is 128 bytes by default). For whole-array erase it is 0.
- R6: A request to set the high-voltage bit is refused if it arrives fewer than SETUP_CYC clocks after the latching write, where SETUP_CYC = ceil(CLK_KHZ*SETUP_US/1000) with a minimum of 1. The same request is accepted at exactly SETUP_CYC clocks.
- R7: A write of 1 to the high-voltage bit is ignored unless program or erase remains selected and the full sequence has completed. `hv_en` shows the bit from the clock after the write.
- R8: Writing 0 to the high-voltage bit, or leaving both select bits 0, drops `hv_en` on the next clock and returns the tracker to idle. A new sequence then needs a fresh selecting write.
- R9: When strobes coincide in one cycle, a control write takes precedence over a flash write, and a flash write takes precedence over a protect read. A strobe that loses is ignored.
- R10: A flash write during the setup wait latches again and restarts the delay. A flash write while high voltage is on leaves `tgt_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| prot_rd | input | 1 | Pulses when the block-protect register is read |
| fl_wr | input | 1 | Pulses on a write into the flash address range |
| fl_addr | input | ADDR_W | Byte address of that flash write |
| hv_en | output | 1 | High-voltage enable to the array |
| tgt_addr | output | ADDR_W | Latched program word or erase page address |

## Verification
The bench builds the block with CLK_KHZ=2000 and SETUP_US=10, which gives a 20-clock setup window. With a window that short, the accept/refuse edge of the high-voltage request is hit in directed tests, and random traffic also completes whole sequences often. ADDR_W=15 and PAGE_BITS=7 cover the full 32 KB range, so page alignment and the whole-array case use real top-of-array addresses.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARMED,
    SQ_PROT,
    SQ_WAIT,
    SQ_HV
  } seq_state_e;

  typedef struct packed {
    logic hv;
    logic mass;
    logic erase;
    logic pgm;
  } ctl_bits_t;
endpackage

// File: rtl/flash_pe_ctlreg.sv
module flash_pe_ctlreg
  import flash_pe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic [7:0] wdata,
  input  logic      hv_grant,
  output ctl_bits_t ctl_q,
  output ctl_bits_t ctl_nxt,
  output logic [7:0] rdata
);
  ctl_bits_t req;
  logic      clash;

  assign req = ctl_bits_t'(wdata[3:0]);

  always_comb begin
    ctl_nxt = ctl_q;
    clash   = 1'b0;
    if (wr) begin
      clash = (req.pgm & req.erase) | (req.pgm & ctl_q.erase) | (req.erase & ctl_q.pgm);
      ctl_nxt.pgm   = clash ? ctl_q.pgm   : req.pgm;
      ctl_nxt.erase = clash ? ctl_q.erase : req.erase;
      ctl_nxt.mass  = req.mass;
      ctl_nxt.hv    = req.hv & (ctl_nxt.pgm | ctl_nxt.erase) & (ctl_q.hv | hv_grant);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_nxt;
  end

  assign rdata = {4'b0000, ctl_q};

  a_r3_no_dual_select: assert property (@(posedge clk) disable iff (rst)
    !(ctl_q.pgm && ctl_q.erase));

  a_r7_hv_needs_select: assert property (@(posedge clk) disable iff (rst)
    ctl_q.hv |-> (ctl_q.pgm || ctl_q.erase));

  a_r8_hv_clear_next: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[3]) |=> !ctl_q.hv);
endmodule

// File: rtl/flash_pe_timer.sv
module flash_pe_timer #(
  parameter int SETUP_CYC = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int CW = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETUP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= LOAD_VAL;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == LOAD_VAL));

  a_r6_countdown: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flash_pe_fsm.sv
module flash_pe_fsm
  import flash_pe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic       prot_rd,
  input  logic       fl_wr,
  input  logic       sel_nxt,
  input  logic       hv_nxt,
  input  logic       hv_on,
  input  logic       timer_done,
  output logic       hv_grant,
  output logic       latch
);
  seq_state_e st_q, st_d;

  assign hv_grant = (st_q == SQ_WAIT) && timer_done;

  always_comb begin
    st_d  = st_q;
    latch = 1'b0;
    if (ctl_wr) begin
      if (!sel_nxt)                        st_d = SQ_IDLE;
      else if (st_q == SQ_IDLE)            st_d = SQ_ARMED;
      else if (st_q == SQ_HV && !hv_nxt)   st_d = SQ_IDLE;
      else if (st_q == SQ_WAIT && hv_nxt)  st_d = SQ_HV;
    end else if (fl_wr) begin
      case (st_q)
        SQ_PROT, SQ_WAIT: begin
          latch = 1'b1;
          st_d  = SQ_WAIT;
        end
        SQ_HV:   st_d = SQ_HV;
        default: st_d = SQ_IDLE;
      endcase
    end else if (prot_rd && st_q == SQ_ARMED) begin
      st_d = SQ_PROT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SQ_IDLE;
    else     st_q <= st_d;
  end

  a_r7_hv_rise_after_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_on) |-> ($past(st_q) == SQ_WAIT && $past(timer_done)));

  a_r8_state_matches_hv: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_HV) == hv_on);

  a_r4_latch_needs_prot: assert property (@(posedge clk) disable iff (rst)
    latch |-> (st_q == SQ_PROT || st_q == SQ_WAIT));
endmodule

// File: rtl/flash_pe_addr_latch.sv
module flash_pe_addr_latch #(
  parameter int ADDR_W    = 15,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              erase,
  input  logic              mass,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] tgt
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] tgt_d;

  always_comb begin
    if (!erase)    tgt_d = addr;
    else if (mass) tgt_d = '0;
    else           tgt_d = addr & PAGE_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)       tgt <= '0;
    else if (load) tgt <= tgt_d;
  end

  a_r10_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(tgt));
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int CLK_KHZ   = 8000,
  parameter int SETUP_US  = 10,
  parameter int ADDR_W    = 15,
  parameter int PAGE_BITS = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              prot_rd,
  input  logic              fl_wr,
  input  logic [ADDR_W-1:0] fl_addr,
  output logic              hv_en,
  output logic [ADDR_W-1:0] tgt_addr
);
  localparam int RAW_CYC   = (CLK_KHZ * SETUP_US + 999) / 1000;
  localparam int SETUP_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  ctl_bits_t ctl_q, ctl_nxt;
  logic      hv_grant, latch, timer_done;

  flash_pe_ctlreg u_ctl (
    .clk      (clk),
    .rst      (rst),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .hv_grant (hv_grant),
    .ctl_q    (ctl_q),
    .ctl_nxt  (ctl_nxt),
    .rdata    (ctl_rdata)
  );

  flash_pe_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ctl_wr     (ctl_wr),
    .prot_rd    (prot_rd),
    .fl_wr      (fl_wr),
    .sel_nxt    (ctl_nxt.pgm | ctl_nxt.erase),
    .hv_nxt     (ctl_nxt.hv),
    .hv_on      (ctl_q.hv),
    .timer_done (timer_done),
    .hv_grant   (hv_grant),
    .latch      (latch)
  );

  flash_pe_timer #(.SETUP_CYC(SETUP_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (latch),
    .done (timer_done)
  );

  flash_pe_addr_latch #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_adr (
    .clk   (clk),
    .rst   (rst),
    .load  (latch),
    .erase (ctl_q.erase),
    .mass  (ctl_q.mass),
    .addr  (fl_addr),
    .tgt   (tgt_addr)
  );

  assign hv_en = ctl_q.hv;
endmodule

// File: tb/flash_pe_seq_bench.sv
module flash_pe_seq_bench;
  localparam int PERIOD    = 10;
  localparam int CLK_KHZ   = 2000;
  localparam int SETUP_US  = 10;
  localparam int ADDR_W    = 15;
  localparam int PAGE_BITS = 7;
  localparam int NSET      = (CLK_KHZ * SETUP_US + 999) / 1000;

  localparam int S_IDLE = 0, S_ARMED = 1, S_PROT = 2, S_WAIT = 3, S_HV = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ctl_wr = 1'b0;
  logic [7:0]        ctl_wdata = '0;
  logic [7:0]        ctl_rdata;
  logic              prot_rd = 1'b0;
  logic              fl_wr = 1'b0;
  logic [ADDR_W-1:0] fl_addr = '0;
  logic              hv_en;
  logic [ADDR_W-1:0] tgt_addr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  logic [3:0]        m_ctl;
  int                m_st, m_lat;
  logic [ADDR_W-1:0] m_tgt;

  always #(PERIOD/2) clk = ~clk;

  flash_pe_seq #(.CLK_KHZ(CLK_KHZ), .SETUP_US(SETUP_US), .ADDR_W(ADDR_W),
                 .PAGE_BITS(PAGE_BITS)) u_flash_pe_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .prot_rd(prot_rd), .fl_wr(fl_wr), .fl_addr(fl_addr), .hv_en(hv_en), .tgt_addr(tgt_addr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_tgt(logic [3:0] c, logic [ADDR_W-1:0] a);
    if (!c[1])     return a;
    else if (c[2]) return '0;
    else           return (a >> PAGE_BITS) << PAGE_BITS;
  endfunction

  task automatic model(bit cw, logic [7:0] wd, bit pr, bit fw, logic [ADDR_W-1:0] fa);
    if (cw) begin
      bit viol, np, ne, sel, grant, nhv;
      viol  = (wd[0] & wd[1]) | (wd[0] & m_ctl[1]) | (wd[1] & m_ctl[0]);
      np    = viol ? m_ctl[0] : wd[0];
      ne    = viol ? m_ctl[1] : wd[1];
      sel   = np | ne;
      grant = (m_st == S_WAIT && (cyc - m_lat) >= NSET) || m_st == S_HV;
      nhv   = wd[3] & sel & grant;
      if (!sel)                         m_st = S_IDLE;
      else if (m_st == S_IDLE)          m_st = S_ARMED;
      else if (m_st == S_HV && !nhv)    m_st = S_IDLE;
      else if (m_st == S_WAIT && nhv)   m_st = S_HV;
      m_ctl = {nhv, wd[2], ne, np};
    end else if (fw) begin
      if (m_st == S_PROT || m_st == S_WAIT) begin
        m_tgt = exp_tgt(m_ctl, fa);
        m_lat = cyc;
        m_st  = S_WAIT;
      end else if (m_st != S_HV) begin
        m_st = S_IDLE;
      end
    end else if (pr && m_st == S_ARMED) begin
      m_st = S_PROT;
    end
  endtask

  task automatic step(string tag, bit cw, logic [7:0] wd, bit pr, bit fw,
                      logic [ADDR_W-1:0] fa);
    @(negedge clk);
    ctl_wr = cw; ctl_wdata = wd; prot_rd = pr; fl_wr = fw; fl_addr = fa;
    @(posedge clk);
    model(cw, wd, pr, fw, fa);
    cyc++;
    #(PERIOD/4);
    ctl_wr = 1'b0; prot_rd = 1'b0; fl_wr = 1'b0;
    chk({tag, " rdata"}, 32'(ctl_rdata), 32'({4'b0, m_ctl}));
    chk({tag, " hv_en"}, 32'(hv_en), 32'(m_ctl[3]));
    chk({tag, " tgt"},   32'(tgt_addr), 32'(m_tgt));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step("idle", 0, 8'h00, 0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    m_ctl = '0; m_st = S_IDLE; m_lat = 0; m_tgt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #(PERIOD/4);
    chk("R1 reset rdata", 32'(ctl_rdata), 32'h0);
    chk("R1 reset hv_en", 32'(hv_en), 32'h0);
    chk("R1 reset tgt",   32'(tgt_addr), 32'h0);

    // R2: upper bits read 0, whole-array bit writable
    step("R2 layout", 1, 8'hF4, 0, 0, '0);
    chk("R2 upper bits zero", 32'(ctl_rdata), 32'h04);
    step("R2 clear", 1, 8'h00, 0, 0, '0);

    // R3: interlock
    step("R3 both", 1, 8'h03, 0, 0, '0);
    chk("R3 both refused", 32'(ctl_rdata), 32'h00);
    step("R3 pgm", 1, 8'h01, 0, 0, '0);
    step("R3 erase while pgm", 1, 8'h06, 0, 0, '0);
    chk("R3 erase refused mass applied", 32'(ctl_rdata), 32'h05);
    step("R3 clear", 1, 8'h00, 0, 0, '0);

    // R4/R7: out-of-order flash write, then hv refused
    step("R4 arm", 1, 8'h02, 0, 0, '0);
    step("R4 early write", 0, 8'h00, 0, 1, 15'h2345);
    step("R4 prot idle", 0, 8'h00, 1, 0, '0);
    step("R4 write idle", 0, 8'h00, 0, 1, 15'h2345);
    chk("R4 no latch", 32'(tgt_addr), 32'h0);
    idle(NSET + 2);
    step("R7 hv out of order", 1, 8'h0A, 0, 0, '0);
    chk("R7 hv refused", 32'(hv_en), 32'h0);
    step("R7 clear", 1, 8'h00, 0, 0, '0);

    // R5/R6: page erase
    step("R5 arm erase", 1, 8'h02, 0, 0, '0);
    step("R5 prot", 0, 8'h00, 1, 0, '0);
    step("R5 latch", 0, 8'h00, 0, 1, 15'h1234);
    chk("R5 page address", 32'(tgt_addr), 32'h1200);
    idle(NSET - 2);
    step("R6 early hv", 1, 8'h0A, 0, 0, '0);
    chk("R6 early hv refused", 32'(hv_en), 32'h0);
    step("R6 hv on time", 1, 8'h0A, 0, 0, '0);
    chk("R6 hv accepted", 32'(hv_en), 32'h1);
    step("R10 write in hv", 0, 8'h00, 0, 1, 15'h7FFF);
    chk("R10 tgt held", 32'(tgt_addr), 32'h1200);
    step("R8 hv clear", 1, 8'h02, 0, 0, '0);
    chk("R8 hv dropped", 32'(hv_en), 32'h0);
    step("R8 clear", 1, 8'h00, 0, 0, '0);

    // R5/R10: program with relatch
    step("R5 arm pgm", 1, 8'h01, 0, 0, '0);
    step("R5 prot", 0, 8'h00, 1, 0, '0);
    step("R5 latch pgm", 0, 8'h00, 0, 1, 15'h0ABC);
    chk("R5 word address", 32'(tgt_addr), 32'h0ABC);
    idle(3);
    step("R10 relatch", 0, 8'h00, 0, 1, 15'h0100);
    chk("R10 relatched", 32'(tgt_addr), 32'h0100);
    idle(NSET - 2);
    step("R10 restarted delay", 1, 8'h09, 0, 0, '0);
    chk("R10 hv refused after restart", 32'(hv_en), 32'h0);
    step("R10 hv after restart", 1, 8'h09, 0, 0, '0);
    chk("R10 hv accepted", 32'(hv_en), 32'h1);
    step("R8 drop select", 1, 8'h08, 0, 0, '0);
    chk("R8 hv off no select", 32'(hv_en), 32'h0);

    // R5: whole-array erase
    step("R5 arm mass", 1, 8'h06, 0, 0, '0);
    step("R5 prot", 0, 8'h00, 1, 0, '0);
    step("R5 latch mass", 0, 8'h00, 0, 1, 15'h5555);
    chk("R5 mass address", 32'(tgt_addr), 32'h0);
    step("R8 clear", 1, 8'h00, 0, 0, '0);

    // R9: priority
    step("R9 arm", 1, 8'h02, 0, 0, '0);
    step("R9 ctl beats prot", 1, 8'h02, 1, 0, '0);
    step("R9 write w/o prot", 0, 8'h00, 0, 1, 15'h0300);
    chk("R9 prot ignored", 32'(tgt_addr), 32'h0);
    step("R9 rearm", 1, 8'h02, 0, 0, '0);
    step("R9 write beats prot", 0, 8'h00, 1, 1, 15'h0380);
    step("R9 write after", 0, 8'h00, 0, 1, 15'h0380);
    chk("R9 no latch", 32'(tgt_addr), 32'h0);

    // random traffic checked against the model
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      logic [7:0] wd;
      r = $urandom % 16;
      case ($urandom % 8)
        0: wd = 8'h01; 1: wd = 8'h02; 2: wd = 8'h06; 3: wd = 8'h09;
        4: wd = 8'h0A; 5: wd = 8'h0E; 6: wd = 8'h00; default: wd = 8'($urandom);
      endcase
      if (r < 3)      step("R3 R7 random ctl", 1, wd, 0, 0, '0);
      else if (r < 5) step("R4 random prot", 0, 8'h00, 1, 0, '0);
      else if (r < 6) step("R5 random write", 0, 8'h00, 0, 1, ADDR_W'($urandom));
      else if (r < 7) step("R9 random mix", $urandom % 2, wd, 1, 1, ADDR_W'($urandom));
      else            step("R6 random idle", 0, 8'h00, 0, 0, '0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule